// File: doc/BRIEF.md
# Hybrid Sector Erase Address Resolver

This block turns an erase request into the exact region of a flash array that the request removes. The array is not uniform. Thirty-two small 4 KB parameter sectors occupy a 128 KB strip at one end of a 32 MB space, and the rest of the space is cut into 64 KB sectors. A write-once placement bit chooses which end holds the small strip. Sector boundaries are fixed. An address that falls anywhere inside a sector selects that whole sector, aligned down to its start. The erase does not begin at the given address.

For each accepted command the block reports the aligned start, the byte size and a linear sector index, or it raises an error flag when the erase type does not match the region or the address is beyond the array. A valid erase then runs a stepper. The stepper issues one clear strobe for each 256-byte buffer chunk across the sector, stays busy until the last chunk, and then pulses done.

Top module: `hybrid_erase_resolver`

## Requirements
- R1: After a synchronous active-low reset, cfg_top, busy, done, clr_strobe and res_valid are all 0, which selects bottom placement.
- R2: A cycle with cfg_wr=1 and cfg_wdata=1 sets cfg_top to 1 from the next cycle. cfg_wdata=0 never changes it, and once it is 1 only reset returns it to 0. A command accepted in the same cycle as the write is resolved with the old placement.
- R3: With cfg_top=0 the small sectors cover [0, 0x20000) with index = address/4096 (0..31). The large sectors follow with index = 32 + (address - 0x20000)/65536 (32..541).
- R4: With cfg_top=1 the large sectors cover [0, 0x1FE0000) with index = address/65536 (0..509). The small sectors cover [0x1FE0000, 0x2000000) with index = 510 + (address - 0x1FE0000)/4096.
- R5: cmd_big=0 requests a 4 KB erase and cmd_big=1 requests a 64 KB erase. Any address inside a sector returns res_start equal to the address rounded down to the sector size, and res_size equal to 4096 or 65536.
- R6: res_err=1 is returned, with res_start, res_size and res_index all 0 and no stepping, for a 4 KB erase outside the small strip, for a 64 KB erase inside it, and for any address at or above 0x2000000.
- R7: A command is accepted when cmd_valid=1 and busy=0. res_valid is 1 for exactly the one cycle after acceptance.
- R8: After a valid acceptance, busy and clr_strobe are 1 for size/256 consecutive cycles, beginning the cycle after acceptance. During cycle k, clr_addr equals res_start + 256*k.
- R9: done is 1 for exactly one cycle, the cycle right after the last strobe, and busy is 0 in that cycle.
- R10: A command presented while busy=1 is ignored. No res_valid appears, and the strobe sequence in progress carries on unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Erase command present |
| cmd_big | input | 1 | 0 = 4 KB erase, 1 = 64 KB erase |
| cmd_addr | input | 32 | Byte address of the erase |
| cfg_wr | input | 1 | Write strobe for the placement bit |
| cfg_wdata | input | 1 | Value written to the placement bit |
| cfg_top | output | 1 | Placement bit: 0 puts the small sectors low, 1 puts them high |
| res_valid | output | 1 | Resolution result valid (one cycle) |
| res_err | output | 1 | Erase rejected |
| res_start | output | 32 | Aligned sector start address |
| res_size | output | 32 | Sector size in bytes |
| res_index | output | 10 | Linear sector index |
| busy | output | 1 | Stepper running |
| clr_strobe | output | 1 | One buffer chunk cleared this cycle |
| clr_addr | output | 32 | Start address of the chunk being cleared |
| done | output | 1 | Last chunk issued (one cycle) |

## Verification
A wrong region decode or a stale placement bit appears on res_index, res_start or res_err one cycle after the command. For that reason the bench sweeps every small sector and a spread of large sectors in both placements, including both edges of the strip. A corrupted cursor or chunk counter appears at the first bad strobe address, or as a strobe count one short or one long, so every strobe of every valid erase is compared and done is checked in its exact cycle. A stepper that does not hold off new commands while busy shows up as a stray res_valid within one cycle of the injected command.

// File: rtl/her_pkg.sv
// Shared definitions for the hybrid erase resolver.
// Assumes the erase address is always a full 4-byte quantity.
package her_pkg;
    localparam int ADDR_W = 32;

    typedef enum logic {
        ERASE_SMALL = 1'b0,
        ERASE_BIG   = 1'b1
    } erase_kind_e;
endpackage

// File: rtl/her_sector_map.sv
// Combinational decode of an erase address into sector start, size and index.
// Assumes NUM_SMALL small sectors together form a whole multiple of one big
// sector, and that the array size is a power of two no larger than 2^31.
module her_sector_map
    import her_pkg::*;
#(
    parameter int ARRAY_LOG2 = 25,
    parameter int SMALL_LOG2 = 12,
    parameter int BIG_LOG2   = 16,
    parameter int NUM_SMALL  = 32,
    parameter int IDX_W      = 10
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  erase_kind_e       kind_i,
    input  logic              top_i,
    output logic              err_o,
    output logic [ADDR_W-1:0] start_o,
    output logic [ADDR_W-1:0] size_o,
    output logic [IDX_W-1:0]  index_o
);
    localparam logic [ADDR_W-1:0] ARR_BYTES   = ADDR_W'(1) << ARRAY_LOG2;
    localparam logic [ADDR_W-1:0] PRM_BYTES   = ADDR_W'(NUM_SMALL) << SMALL_LOG2;
    localparam logic [ADDR_W-1:0] TOP_BASE    = ARR_BYTES - PRM_BYTES;
    localparam logic [ADDR_W-1:0] NUM_BIG     = TOP_BASE >> BIG_LOG2;
    localparam logic [ADDR_W-1:0] SMALL_BYTES = ADDR_W'(1) << SMALL_LOG2;
    localparam logic [ADDR_W-1:0] BIG_BYTES   = ADDR_W'(1) << BIG_LOG2;

    logic              out_of_range;
    logic              in_strip;
    logic [ADDR_W-1:0] strip_base;
    logic [ADDR_W-1:0] strip_off;
    logic [ADDR_W-1:0] big_off;
    logic [ADDR_W-1:0] small_idx;
    logic [ADDR_W-1:0] big_idx;

    // Locate the address relative to the small-sector strip.
    always_comb begin
        out_of_range = (addr_i >= ARR_BYTES);
        strip_base   = top_i ? TOP_BASE : '0;
        strip_off    = addr_i - strip_base;
        in_strip     = !out_of_range && (addr_i >= strip_base) && (strip_off < PRM_BYTES);
        big_off      = top_i ? addr_i : (addr_i - PRM_BYTES);
        small_idx    = (top_i ? NUM_BIG : '0) + (strip_off >> SMALL_LOG2);
        big_idx      = (top_i ? '0 : ADDR_W'(NUM_SMALL)) + (big_off >> BIG_LOG2);
    end

    // Select the result for the requested erase kind, or flag a mismatch.
    always_comb begin
        err_o   = 1'b0;
        start_o = '0;
        size_o  = '0;
        index_o = '0;
        if (out_of_range) begin
            err_o = 1'b1;
        end else if (kind_i == ERASE_SMALL) begin
            if (!in_strip) begin
                err_o = 1'b1;
            end else begin
                start_o = addr_i & ~(SMALL_BYTES - 1'b1);
                size_o  = SMALL_BYTES;
                index_o = IDX_W'(small_idx);
            end
        end else begin
            if (in_strip) begin
                err_o = 1'b1;
            end else begin
                start_o = addr_i & ~(BIG_BYTES - 1'b1);
                size_o  = BIG_BYTES;
                index_o = IDX_W'(big_idx);
            end
        end
    end
endmodule

// File: rtl/her_placement_cell.sv
// Write-once placement bit: may move from 0 to 1, never back, except by reset.
// Assumes reset models a power-on of the configuration cell.
module her_placement_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_i,
    input  logic wdata_i,
    output logic q_o
);
    // Hold the bit; only a write of 1 can change it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_o <= 1'b0;
        end else if (wr_i && wdata_i) begin
            q_o <= 1'b1;
        end
    end
endmodule

// File: rtl/her_range_stepper.sv
// Walks an erased range one buffer chunk per cycle and flags completion.
// Assumes launch_i is only asserted while busy_o is low.
module her_range_stepper
    import her_pkg::*;
#(
    parameter int CHUNK_LOG2 = 8,
    parameter int CNT_W      = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [CNT_W-1:0]  chunks_i,
    output logic              busy_o,
    output logic              strobe_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              done_o
);
    localparam logic [ADDR_W-1:0] CHUNK_BYTES = ADDR_W'(1) << CHUNK_LOG2;

    logic [ADDR_W-1:0] cursor;
    logic [CNT_W-1:0]  remain;

    // Advance the cursor and chunk count; finish on the last chunk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o <= 1'b0;
            done_o <= 1'b0;
            cursor <= '0;
            remain <= '0;
        end else begin
            done_o <= 1'b0;
            if (launch_i) begin
                busy_o <= 1'b1;
                cursor <= base_i;
                remain <= chunks_i;
            end else if (busy_o) begin
                cursor <= cursor + CHUNK_BYTES;
                remain <= remain - 1'b1;
                if (remain == CNT_W'(1)) begin
                    busy_o <= 1'b0;
                    done_o <= 1'b1;
                end
            end
        end
    end

    // A chunk is issued in every busy cycle at the current cursor.
    always_comb begin
        strobe_o = busy_o;
        addr_o   = cursor;
    end
endmodule

// File: rtl/hybrid_erase_resolver.sv
// Top of the hybrid erase resolver: accepts erase commands, registers the
// resolved sector, and runs the chunk stepper for valid erases.
// Assumes the caller observes busy and does not rely on commands given while busy.
module hybrid_erase_resolver
    import her_pkg::*;
#(
    parameter int ARRAY_LOG2 = 25,
    parameter int SMALL_LOG2 = 12,
    parameter int BIG_LOG2   = 16,
    parameter int NUM_SMALL  = 32,
    parameter int CHUNK_LOG2 = 8,
    parameter int IDX_W      = $clog2(NUM_SMALL + ((1 << ARRAY_LOG2) - (NUM_SMALL << SMALL_LOG2)) / (1 << BIG_LOG2))
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_big,
    input  logic [31:0]       cmd_addr,
    input  logic              cfg_wr,
    input  logic              cfg_wdata,
    output logic              cfg_top,
    output logic              res_valid,
    output logic              res_err,
    output logic [31:0]       res_start,
    output logic [31:0]       res_size,
    output logic [IDX_W-1:0]  res_index,
    output logic              busy,
    output logic              clr_strobe,
    output logic [31:0]       clr_addr,
    output logic              done
);
    localparam int CNT_W = BIG_LOG2 - CHUNK_LOG2 + 1;

    erase_kind_e       kind;
    logic              accept;
    logic              map_err;
    logic [ADDR_W-1:0] map_start;
    logic [ADDR_W-1:0] map_size;
    logic [IDX_W-1:0]  map_index;
    logic [CNT_W-1:0]  map_chunks;

    // Decode the command kind and the acceptance condition.
    always_comb begin
        kind       = erase_kind_e'(cmd_big);
        accept     = cmd_valid && !busy;
        map_chunks = CNT_W'(map_size >> CHUNK_LOG2);
    end

    her_placement_cell u_place (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (cfg_wr),
        .wdata_i (cfg_wdata),
        .q_o     (cfg_top)
    );

    her_sector_map #(
        .ARRAY_LOG2 (ARRAY_LOG2),
        .SMALL_LOG2 (SMALL_LOG2),
        .BIG_LOG2   (BIG_LOG2),
        .NUM_SMALL  (NUM_SMALL),
        .IDX_W      (IDX_W)
    ) u_map (
        .addr_i  (cmd_addr),
        .kind_i  (kind),
        .top_i   (cfg_top),
        .err_o   (map_err),
        .start_o (map_start),
        .size_o  (map_size),
        .index_o (map_index)
    );

    // Register the resolution of each accepted command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_err   <= 1'b0;
            res_start <= '0;
            res_size  <= '0;
            res_index <= '0;
        end else begin
            res_valid <= accept;
            if (accept) begin
                res_err   <= map_err;
                res_start <= map_start;
                res_size  <= map_size;
                res_index <= map_index;
            end
        end
    end

    her_range_stepper #(
        .CHUNK_LOG2 (CHUNK_LOG2),
        .CNT_W      (CNT_W)
    ) u_step (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch_i (accept && !map_err),
        .base_i   (map_start),
        .chunks_i (map_chunks),
        .busy_o   (busy),
        .strobe_o (clr_strobe),
        .addr_o   (clr_addr),
        .done_o   (done)
    );
endmodule

// File: rtl/hybrid_erase_resolver_chk.sv
// Property checker for the hybrid erase resolver, attached by bind.
module hybrid_erase_resolver_chk #(
    parameter int CHUNK_LOG2 = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_valid,
    input logic [31:0] cmd_addr,
    input logic        cfg_top,
    input logic        res_valid,
    input logic        res_err,
    input logic [31:0] res_start,
    input logic [31:0] res_size,
    input logic        busy,
    input logic        clr_strobe,
    input logic [31:0] clr_addr,
    input logic        done
);
    AST_PLACE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_top |=> cfg_top); // R2

    AST_ADDR_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_err) |-> (($past(cmd_addr) >= res_start) &&
                                     (($past(cmd_addr) - res_start) < res_size))); // R5

    AST_START_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_err) |-> ((res_start & (res_size - 32'd1)) == 32'd0)); // R5

    AST_ERR_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_err) |-> (!busy && res_size == 32'd0)); // R6

    AST_RES_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid); // R7

    AST_CHUNK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_strobe && $past(clr_strobe)) |-> (clr_addr == $past(clr_addr) + (32'd1 << CHUNK_LOG2))); // R8

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy))); // R9

    AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_valid) |=> !res_valid); // R10
endmodule

bind hybrid_erase_resolver hybrid_erase_resolver_chk #(.CHUNK_LOG2(CHUNK_LOG2)) u_chk (.*);

// File: tb/hybrid_erase_resolver_tb_top.sv
module hybrid_erase_resolver_tb_top;
    localparam longint ARR  = 64'h0200_0000;
    localparam longint PRM  = 64'h0002_0000;
    localparam longint TOPB = ARR - PRM;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_big = 1'b0;
    logic [31:0] cmd_addr = '0;
    logic        cfg_wr = 1'b0;
    logic        cfg_wdata = 1'b0;
    logic        cfg_top, res_valid, res_err, busy, clr_strobe, done;
    logic [31:0] res_start, res_size, clr_addr;
    logic [9:0]  res_index;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    hybrid_erase_resolver dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_big(cmd_big),
        .cmd_addr(cmd_addr), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_top(cfg_top), .res_valid(res_valid), .res_err(res_err),
        .res_start(res_start), .res_size(res_size), .res_index(res_index),
        .busy(busy), .clr_strobe(clr_strobe), .clr_addr(clr_addr), .done(done)
    );

    task automatic chk(input bit ok, input string req, input string info);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s", req, info);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    // Arithmetic reference for the hybrid sector map.
    task automatic model(input bit top, input bit big, input longint a,
                         output bit err, output longint st, output longint sz,
                         output longint idx);
        bit in_strip;
        in_strip = top ? (a >= TOPB && a < ARR) : (a < PRM);
        err = 1'b0; st = 0; sz = 0; idx = 0;
        if (a >= ARR || big == in_strip) begin
            err = 1'b1;
        end else if (!big) begin
            sz = 4096; st = (a / 4096) * 4096;
            idx = top ? 510 + (a - TOPB) / 4096 : a / 4096;
        end else begin
            sz = 65536; st = (a / 65536) * 65536;
            idx = top ? a / 65536 : 32 + (a - PRM) / 65536;
        end
    endtask

    // Issue one erase and check result, strobes and completion.
    task automatic erase(input bit big, input longint a, input bit inject, input string req);
        bit e; longint st, sz, idx; int n; bit bad;
        model(cfg_top, big, a, e, st, sz, idx);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_big = big; cmd_addr = a[31:0];
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(res_valid && res_err == e && res_start == st[31:0] && res_size == sz[31:0] &&
            res_index == idx[9:0], req,
            $sformatf("addr=%h big=%0d got v=%0d err=%0d start=%h size=%0d idx=%0d exp err=%0d start=%h size=%0d idx=%0d",
                      a, big, res_valid, res_err, res_start, res_size, res_index, e, st, sz, idx));
        if (e) begin
            chk(!busy && !clr_strobe, "R6", $sformatf("busy=%0d strobe=%0d exp 0 0", busy, clr_strobe));
            @(negedge clk);
            chk(!res_valid && !busy, "R7", $sformatf("res_valid=%0d busy=%0d exp 0 0", res_valid, busy));
            return;
        end
        n = int'(sz / 256);
        bad = 1'b0;
        for (int k = 0; k < n; k++) begin
            if (!clr_strobe || !busy || clr_addr != 32'(st + 256 * k) || (k > 0 && res_valid) || done) begin
                if (!bad) $display("FAIL R8: chunk %0d strobe=%0d addr=%h res_valid=%0d exp strobe=1 addr=%h",
                                   k, clr_strobe, clr_addr, res_valid, 32'(st + 256 * k));
                bad = 1'b1;
            end
            if (inject && k == 3) begin
                cmd_valid = 1'b1; cmd_big = 1'b0; cmd_addr = 32'h0000_4000;
            end
            if (inject && k == 4) cmd_valid = 1'b0;
            @(negedge clk);
        end
        checks++;
        if (bad) fails++;
        chk(done && !busy && !clr_strobe && !res_valid, inject ? "R10" : "R9",
            $sformatf("done=%0d busy=%0d strobe=%0d res_valid=%0d exp 1 0 0 0", done, busy, clr_strobe, res_valid));
        @(negedge clk);
        chk(!done && !busy, "R9", $sformatf("done=%0d busy=%0d exp 0 0", done, busy));
    endtask

    task automatic sweep(input bit top);
        longint sb = top ? TOPB : 0;
        longint bb = top ? 0 : PRM;
        for (int s = 0; s < 32; s++)
            erase(1'b0, sb + s * 4096 + (s * 131) % 4096, 1'b0, top ? "R4" : "R3");
        for (int b = 0; b < 510; b += 7)
            erase(1'b1, bb + b * 65536 + (b * 977) % 65536, 1'b0, top ? "R4" : "R3");
        erase(1'b1, bb + 65536 * 509 + 65535, 1'b0, "R5");
        erase(1'b0, sb + PRM - 1, 1'b0, "R5");
        erase(1'b1, bb + 65536 * 20 + 12345, 1'b1, "R10");
        erase(1'b0, top ? TOPB - 1 : PRM, 1'b0, "R6");
        erase(1'b1, top ? TOPB : PRM - 1, 1'b0, "R6");
        erase(1'b0, ARR, 1'b0, "R6");
        erase(1'b1, 64'hFFFF_FFFF, 1'b0, "R6");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!cfg_top && !busy && !done && !clr_strobe && !res_valid, "R1",
            $sformatf("top=%0d busy=%0d done=%0d strobe=%0d rv=%0d exp all 0", cfg_top, busy, done, clr_strobe, res_valid));
        rst_n = 1'b1;
        @(negedge clk);
        sweep(1'b0);
        // R2: writing 0 does nothing
        cfg_wr = 1'b1; cfg_wdata = 1'b0;
        @(negedge clk);
        cfg_wr = 1'b0;
        @(negedge clk);
        chk(!cfg_top, "R2", $sformatf("cfg_top=%0d exp 0", cfg_top));
        // R2: write 1 together with a command; command sees old placement
        cfg_wr = 1'b1; cfg_wdata = 1'b1;
        cmd_valid = 1'b1; cmd_big = 1'b0; cmd_addr = 32'h0000_1010;
        @(negedge clk);
        cfg_wr = 1'b0; cmd_valid = 1'b0;
        chk(cfg_top && res_valid && !res_err && res_index == 10'd1 && res_start == 32'h1000, "R2",
            $sformatf("top=%0d err=%0d idx=%0d start=%h exp 1 0 1 00001000", cfg_top, res_err, res_index, res_start));
        while (busy) @(negedge clk);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_wdata = 1'b0;
        @(negedge clk);
        cfg_wr = 1'b0;
        @(negedge clk);
        chk(cfg_top, "R2", $sformatf("cfg_top=%0d exp 1 after writing 0", cfg_top));
        sweep(1'b1);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(!cfg_top && !busy && !res_valid, "R1",
            $sformatf("after reset top=%0d busy=%0d rv=%0d exp 0 0 0", cfg_top, busy, res_valid));
        summary();
    end

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, exp completion");
        summary();
    end
endmodule